// File: doc/BRIEF.md
# Two-Wire Configuration Register Target

This block is a two-wire serial bus target that owns a small, sparsely populated configuration register file for a clock-routing section of a chip. It watches the bus clock and data lines through synchronisers and a short glitch filter running on a faster system clock. It recognises start, repeated start and stop conditions, and answers only to the 7-bit address 0x69. It pulls the data line low through an open-drain enable and never stretches the bus clock.

A write frame carries a register pointer followed by any number of data bytes, which land in consecutive registers. A read frame first sets the pointer with a write, then issues a repeated start with the read bit set. The target then streams consecutive registers until the controller answers with a NACK. Every implemented register is presented in parallel on one flat output bus for the clock-routing logic. Reserved bit fields hold fixed patterns whatever is written.

Top module: `i2c_cfg_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits are 0x69, by pulling SDA low during the ninth clock. For any other address it leaves SDA released on that clock and on every later clock until the next START, and no register changes.
- R2: In a write frame (address byte bit 0 = 0), the first byte after the address loads the register pointer. Each later byte is written to the register at the pointer, the pointer then advances by one, and every such byte is acknowledged on its ninth clock.
- R3: The register pointer wraps from 0xFF to 0x00, both during write bursts and during read bursts.
- R4: After a repeated START and an address byte with bit 0 = 1, the target sends the register at the pointer MSB first and advances the pointer after each byte. It continues while the controller acknowledges, and releases SDA for good after a controller NACK.
- R5: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A START at any point restarts address reception. SDA driven by the target changes only while SCL is low.
- R6: Fixed fields: register 0x40 bits 7:5 always hold 110, register 0x46 bits 5:0 always hold 111111, register 0x12 always holds 0,0,1 in bits 7:5 and 0,0,0 in bits 2:0 (only bits 4:3 are writable), and register 0x09 bits 7:6 always hold 00.
- R7: After reset, registers 0x0C and 0x47 hold 0x08, and 0x12 holds 0x20. 0x40 holds 0xC0, 0x46 holds 0x3F, and all other implemented registers, including the output-enable register 0x09, hold 0x00. SDA is released.
- R8: Addresses other than 0x09, 0x0C, 0x12, 0x13, 0x40, 0x41, 0x42, 0x44, 0x45, 0x46 and 0x47 are reserved. Writes to them are acknowledged and discarded, and reads from them return 0x00.
- R9: A pulse on SCL or SDA lasting a single system clock is ignored. It neither counts as a bus clock nor forms a START or STOP.
- R10: The output `cfg_image` carries register 0x09 in bits 7:0, then 0x0C, 0x12, 0x13, 0x40, 0x41, 0x42, 0x44, 0x45, 0x46 and 0x47 in successive bytes, with 0x47 in bits 87:80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| cfg_image | output | 88 | All implemented registers side by side (layout in R10) |

## Verification
A bus line change takes six system clocks to reach `sda_oe`: two synchroniser stages, two filter samples, the filter output flop and the framing register. A written byte appears on `cfg_image` one clock after the acknowledge is driven. The bench therefore changes SDA only ten clocks after an SCL fall, and samples acknowledge and read bits ten clocks into the SCL high phase, well past that latency. The bench's register model is compared with `cfg_image` on every clock, except in the window between the start of a data byte and the model update at its acknowledge. That window is where the commit may legally happen.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

  localparam int NREG = 11;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_PTR, ST_WDATA, ST_ACK,
    ST_RDATA, ST_MACK, ST_MACK_OK, ST_IGNORE
  } tgt_state_e;

  // Bus address of implemented register k; k also selects its byte in the image.
  function automatic logic [7:0] reg_addr(input int k);
    case (k)
      0: return 8'h09;
      1: return 8'h0C;
      2: return 8'h12;
      3: return 8'h13;
      4: return 8'h40;
      5: return 8'h41;
      6: return 8'h42;
      7: return 8'h44;
      8: return 8'h45;
      9: return 8'h46;
      default: return 8'h47;
    endcase
  endfunction

  // Bits set here are forced to fix_val and never take written data.
  function automatic logic [7:0] fix_mask(input int k);
    case (k)
      0: return 8'hC0;
      2: return 8'hE7;
      4: return 8'hE0;
      9: return 8'h3F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] fix_val(input int k);
    case (k)
      2: return 8'h20;
      4: return 8'hC0;
      9: return 8'h3F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reg_default(input int k);
    if (k == 1 || k == 10) return 8'h08;
    return fix_val(k);
  endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES  = 2,
  parameter int FILT_SAMPLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_out
);

  logic [SYNC_STAGES-1:0]  sync_q;
  logic [FILT_SAMPLES-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= '1;
      hist_q   <= '1;
      line_out <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
      hist_q <= {hist_q[FILT_SAMPLES-2:0], sync_q[SYNC_STAGES-1]};
      if (&hist_q)
        line_out <= 1'b1;
      else if (~|hist_q)
        line_out <= 1'b0;
    end
  end

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import i2c_cfg_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [7:0]          waddr,
  input  logic [7:0]          wdata,
  input  logic [7:0]          raddr,
  output logic [7:0]          rdata,
  output logic [NREG*8-1:0]   image
);

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    localparam logic [7:0] ADDR_K = reg_addr(k);
    localparam logic [7:0] MASK_K = fix_mask(k);
    localparam logic [7:0] VAL_K  = fix_val(k);
    localparam logic [7:0] DEF_K  = reg_default(k);
    logic [7:0] q;

    always_ff @(posedge clk) begin
      if (rst)
        q <= DEF_K;
      else if (we && waddr == ADDR_K)
        q <= (wdata & ~MASK_K) | (VAL_K & MASK_K);
    end

    assign image[8*k +: 8] = q;
  end

  // Unmatched (reserved) addresses read as zero.
  always_comb begin
    rdata = 8'h00;
    for (int k = 0; k < NREG; k++)
      if (raddr == reg_addr(k)) rdata = image[8*k +: 8];
  end

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl,
  input  logic       sda,
  input  logic [7:0] rdata,
  output logic [7:0] ptr,
  output logic       we,
  output logic [7:0] waddr,
  output logic [7:0] wdata,
  output logic       sda_oe
);

  tgt_state_e state, nxt;
  logic       scl_q, sda_q;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txsh;
  logic       start_ev, stop_ev, rise, fall;

  assign start_ev = scl && scl_q && sda_q && !sda;
  assign stop_ev  = scl && scl_q && !sda_q && sda;
  assign rise     = scl && !scl_q;
  assign fall     = !scl && scl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      state  <= ST_IDLE;
      nxt    <= ST_PTR;
      bitcnt <= '0;
      shreg  <= '0;
      txsh   <= '0;
      ptr    <= '0;
      we     <= 1'b0;
      waddr  <= '0;
      wdata  <= '0;
      sda_oe <= 1'b0;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
      we    <= 1'b0;
      if (start_ev) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (rise) begin
              shreg  <= {shreg[6:0], sda};
              bitcnt <= bitcnt + 4'd1;
            end else if (fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (state == ST_ADDR) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  nxt    <= shreg[0] ? ST_RDATA : ST_PTR;
                  sda_oe <= 1'b1;
                  state  <= ST_ACK;
                end else begin
                  state  <= ST_IGNORE;
                end
              end else begin
                if (state == ST_PTR) begin
                  ptr <= shreg;
                end else begin
                  we    <= 1'b1;
                  waddr <= ptr;
                  wdata <= shreg;
                  ptr   <= ptr + 8'd1;
                end
                nxt    <= ST_WDATA;
                sda_oe <= 1'b1;
                state  <= ST_ACK;
              end
            end
          end
          ST_ACK: begin
            if (fall) begin
              bitcnt <= '0;
              state  <= nxt;
              if (nxt == ST_RDATA) begin
                sda_oe <= ~rdata[7];
                txsh   <= {rdata[6:0], 1'b0};
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
          ST_RDATA: begin
            if (rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                ptr    <= ptr + 8'd1;
                bitcnt <= '0;
                state  <= ST_MACK;
              end else begin
                sda_oe <= ~txsh[7];
                txsh   <= {txsh[6:0], 1'b0};
              end
            end
          end
          ST_MACK: begin
            if (rise) state <= sda ? ST_IGNORE : ST_MACK_OK;
          end
          ST_MACK_OK: begin
            if (fall) begin
              sda_oe <= ~rdata[7];
              txsh   <= {rdata[6:0], 1'b0};
              bitcnt <= '0;
              state  <= ST_RDATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR     = 7'h69,
  parameter int         SYNC_STAGES  = 2,
  parameter int         FILT_SAMPLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic [NREG*8-1:0] cfg_image
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, filt_lines;
  logic [7:0]        ptr, waddr, wdata, rdata;
  logic              we;

  assign raw_lines = {sda_in, scl_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_line_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .FILT_SAMPLES(FILT_SAMPLES)
    ) u_filt (
      .clk     (clk),
      .rst     (rst),
      .line_in (raw_lines[g]),
      .line_out(filt_lines[g])
    );
  end

  i2c_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk   (clk),
    .rst   (rst),
    .scl   (filt_lines[0]),
    .sda   (filt_lines[1]),
    .rdata (rdata),
    .ptr   (ptr),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .sda_oe(sda_oe)
  );

  cfg_regbank u_regs (
    .clk  (clk),
    .rst  (rst),
    .we   (we),
    .waddr(waddr),
    .wdata(wdata),
    .raddr(ptr),
    .rdata(rdata),
    .image(cfg_image)
  );

endmodule

// File: rtl/cfg_target_chk.sv
module cfg_target_chk
  import i2c_cfg_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              scl_in,
  input logic              sda_oe,
  input logic [NREG*8-1:0] cfg_image
);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sda_oe && cfg_image[7:0] == 8'h00)); // R7

  AST_FIXED_R40: assert property (@(posedge clk) disable iff (rst)
    cfg_image[39:37] == 3'b110); // R6

  AST_FIXED_R46: assert property (@(posedge clk) disable iff (rst)
    cfg_image[77:72] == 6'h3F); // R6

  AST_FIXED_R12_R09: assert property (@(posedge clk) disable iff (rst)
    ((cfg_image[23:16] & 8'hE7) == 8'h20) && (cfg_image[7:6] == 2'b00)); // R6

  AST_WRITE_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_image) |-> sda_oe); // R2

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_in); // R5

endmodule

bind i2c_cfg_target cfg_target_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_in   (scl_in),
  .sda_oe   (sda_oe),
  .cfg_image(cfg_image)
);

// File: tb/i2c_cfg_target_tb_top.sv
`timescale 1ns/1ps
module i2c_cfg_target_tb_top;

  localparam int NR = 11;
  localparam logic [7:0] ORDER [NR] = '{8'h09, 8'h0C, 8'h12, 8'h13, 8'h40,
                                        8'h41, 8'h42, 8'h44, 8'h45, 8'h46, 8'h47};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_drv = 1'b1;
  logic sda_drv = 1'b1;
  logic glitch_en = 1'b0;
  logic img_sync = 1'b1;
  logic done = 1'b0;
  logic sda_oe;
  logic sda_in;
  logic [NR*8-1:0] cfg_image;
  logic [7:0] wq[$];
  int mdl [256];
  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  assign sda_in = sda_drv & ~sda_oe;

  i2c_cfg_target dut_i (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_drv),
    .sda_in   (sda_in),
    .sda_oe   (sda_oe),
    .cfg_image(cfg_image)
  );

  // Register model built from the requirement text (R6, R7, R8).
  function automatic bit m_impl(input logic [7:0] a);
    foreach (ORDER[k]) if (ORDER[k] == a) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [7:0] m_mask(input logic [7:0] a);
    case (a)
      8'h09: return 8'hC0;
      8'h12: return 8'hE7;
      8'h40: return 8'hE0;
      8'h46: return 8'h3F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] m_fixed(input logic [7:0] a);
    case (a)
      8'h12: return 8'h20;
      8'h40: return 8'hC0;
      8'h46: return 8'h3F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] m_default(input logic [7:0] a);
    if (a == 8'h0C || a == 8'h47) return 8'h08;
    return m_fixed(a);
  endfunction

  function automatic void m_write(input logic [7:0] a, input logic [7:0] d);
    if (m_impl(a)) mdl[a] = (d & ~m_mask(a)) | (m_fixed(a) & m_mask(a));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Per-clock comparison of the image against the model (R2, R6, R7, R10).
  always @(negedge clk) begin
    logic [NR*8-1:0] e;
    if (!rst && img_sync) begin
      for (int k = 0; k < NR; k++) e[8*k +: 8] = mdl[ORDER[k]][7:0];
      n_chk++;
      if (cfg_image !== e) begin
        n_err++;
        $display("FAIL R10/R2/R6/R7 image: actual %h expected %h", cfg_image, e);
      end
    end
  end

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    sda_drv = b;
    hw(10);
    scl_drv = 1'b1;
    if (glitch_en) begin
      hw(10);
      scl_drv = 1'b0;
      hw(1);
      scl_drv = 1'b1;
      hw(9);
    end else begin
      hw(20);
    end
    scl_drv = 1'b0;
    hw(10);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; hw(10);
    scl_drv = 1'b1; hw(10);
    sda_drv = 1'b0; hw(10);
    scl_drv = 1'b0; hw(10);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; hw(10);
    scl_drv = 1'b1; hw(10);
    sda_drv = 1'b1; hw(20);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_drv = 1'b1; hw(10);
    scl_drv = 1'b1; hw(10);
    acked = (sda_in == 1'b0);
    hw(10);
    scl_drv = 1'b0; hw(10);
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    sda_drv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(10);
      scl_drv = 1'b1; hw(10);
      b[i] = sda_in;
      hw(10);
      scl_drv = 1'b0;
    end
    hw(10);
    sda_drv = ack ? 1'b0 : 1'b1;
    hw(10);
    scl_drv = 1'b1; hw(20);
    scl_drv = 1'b0; hw(10);
    sda_drv = 1'b1;
  endtask

  // Write frame with the bytes in wq; dev other than 0x69 expects NACKs (R1).
  task automatic write_frame(input logic [6:0] dev, input logic [7:0] p0, input string req);
    bit ak;
    bit match;
    logic [7:0] p;
    match = (dev == 7'h69);
    p = p0;
    bus_start();
    send_byte({dev, 1'b0}, ak);
    chk(ak == match, req, "address ack", ak, match);
    send_byte(p0, ak);
    chk(ak == match, req, "pointer ack", ak, match);
    foreach (wq[i]) begin
      img_sync = 1'b0;
      send_byte(wq[i], ak);
      chk(ak == match, req, "data ack", ak, match);
      if (match) m_write(p, wq[i]);
      p = p + 8'd1;
      img_sync = 1'b1;
    end
    bus_stop();
    chk(sda_oe == 1'b0, "R5", "released after stop", sda_oe, 0);
  endtask

  // Read n bytes; set_ptr=0 reads from the pointer left by earlier frames (R4).
  task automatic read_frame(input bit set_ptr, input logic [7:0] p0, inout logic [7:0] p,
                            input int n, input string req);
    bit ak;
    logic [7:0] b;
    bus_start();
    if (set_ptr) begin
      send_byte({7'h69, 1'b0}, ak);
      chk(ak, req, "address ack (write)", ak, 1);
      send_byte(p0, ak);
      chk(ak, req, "pointer ack", ak, 1);
      p = p0;
      bus_start();
    end
    send_byte({7'h69, 1'b1}, ak);
    chk(ak, req, "address ack (read)", ak, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      chk(b == mdl[p][7:0], req, "read data", b, mdl[p][7:0]);
      p = p + 8'd1;
    end
    hw(5);
    chk(sda_oe == 1'b0, "R4", "released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] rp;
    bit ak;
    for (int a = 0; a < 256; a++) mdl[a] = m_default(8'(a));
    rp = 8'h00;
    hw(5);
    rst = 1'b0;
    hw(3);
    // R7: reset state
    chk(sda_oe == 1'b0, "R7", "sda_oe after reset", sda_oe, 0);
    chk(cfg_image[7:0] == 8'h00, "R7", "output enables off", cfg_image[7:0], 0);
    chk(cfg_image[87:80] == 8'h08, "R7", "reg 0x47 default", cfg_image[87:80], 8);

    // R2/R6: output-enable register, top bits forced to zero
    wq = '{8'hFF};
    write_frame(7'h69, 8'h09, "R2");
    chk(cfg_image[7:0] == 8'h3F, "R6", "reg 0x09 bits 7:6", cfg_image[7:0], 8'h3F);

    // R2/R6: burst across 0x44..0x46
    wq = '{8'h12, 8'h34, 8'h56};
    write_frame(7'h69, 8'h44, "R2");
    chk(cfg_image[79:72] == 8'h7F, "R6", "reg 0x46 low bits", cfg_image[79:72], 8'h7F);

    // R6: fixed fields in 0x12 and 0x40
    wq = '{8'hFF, 8'hA5};
    write_frame(7'h69, 8'h12, "R6");
    chk(cfg_image[23:16] == 8'h38, "R6", "reg 0x12 pattern", cfg_image[23:16], 8'h38);
    wq = '{8'h1F, 8'hBE, 8'h81};
    write_frame(7'h69, 8'h40, "R6");
    chk(cfg_image[39:32] == 8'hDF, "R6", "reg 0x40 pattern", cfg_image[39:32], 8'hDF);

    // R4: read burst with controller ACKs, then NACK; then continue without pointer
    read_frame(1'b1, 8'h40, rp, 3, "R4");
    read_frame(1'b0, 8'h00, rp, 2, "R4");

    // R1: wrong device address is NACKed and changes nothing
    wq = '{8'h00, 8'h11};
    write_frame(7'h55, 8'h09, "R1");

    // R8: reserved address write acknowledged, read back zero
    wq = '{8'h77};
    write_frame(7'h69, 8'h20, "R8");
    read_frame(1'b1, 8'h20, rp, 1, "R8");

    // R3: pointer wrap, eleventh byte from 0xFF lands in 0x09
    wq = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'hC3};
    write_frame(7'h69, 8'hFF, "R3");
    chk(cfg_image[7:0] == 8'h03, "R3", "wrapped write to 0x09", cfg_image[7:0], 3);
    read_frame(1'b1, 8'hFE, rp, 3, "R3");

    // R9: one-clock SCL pulses inside each high phase are ignored
    glitch_en = 1'b1;
    wq = '{8'h9C};
    write_frame(7'h69, 8'h41, "R9");
    glitch_en = 1'b0;
    chk(cfg_image[47:40] == 8'h9C, "R9", "reg 0x41 after glitches", cfg_image[47:40], 8'h9C);

    // R5: repeated START in the middle of the pointer byte restarts framing
    bus_start();
    send_byte({7'h69, 1'b0}, ak);
    chk(ak, "R5", "address ack before abort", ak, 1);
    put_bit(1'b1);
    put_bit(1'b0);
    put_bit(1'b1);
    wq = '{8'h5A};
    write_frame(7'h69, 8'h13, "R5");
    chk(cfg_image[31:24] == 8'h5A, "R5", "reg 0x13 after restart", cfg_image[31:24], 8'h5A);

    hw(20);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule